// File: doc/BRIEF.md
# Receive Holding FIFO with Per-Character Line Status

This block is the receive-side holding buffer of a serial port. A receive shift register hands it one assembled character per `push_valid` pulse, along with three error flags for that character: parity, framing and break. The block queues the character and its flags together, so the flags always stay with their character. The host reads the oldest character from the head outputs and removes it with a one-cycle `pop` strobe.

The buffer has two modes, selected by `fifo_en`. With `fifo_en` high it is a queue of `DEPTH` entries, 64 by default. With `fifo_en` low only storage slot zero is used, so the buffer holds a single character.

The block also produces the receive line-status bits. `data_ready` shows that something is waiting. `overrun` records that a character was lost. `fifo_err` summarises whether any waiting character is damaged. The per-character parity, framing and break flags are shown for the head entry only. A one-cycle `flush` strobe empties the queue, and `fifo_en` is expected to change only while the queue is empty.

Top module: `rx_hold_fifo`

## Requirements
- R1: After reset: `level` is 0, and `data_ready`, `overrun` and `fifo_err` are all 0.
- R2: With `fifo_en`=1, up to 64 characters are accepted. They leave through the head outputs in the order they arrived.
- R3: With `fifo_en`=1 and `level`=64, a push is discarded. `level` and the queued contents stay unchanged, and `overrun` is 1 after that clock edge.
- R4: With `fifo_en`=0 the capacity is one character. A second push before a pop is discarded and sets `overrun`, and the first character stays at the head.
- R5: `head_pe`, `head_fe` and `head_brk` are the flags that were pushed with the character now shown on `head_data`.
- R6: `fifo_err` is 1 exactly while at least one queued entry has any of its three error flags set.
- R7: `lsr_rd` clears `overrun` at the next edge. If a discarded push falls in the same cycle as `lsr_rd`, `overrun` ends up 1.
- R8: `data_ready` is 1 exactly when `level` is non-zero.
- R9: `flush` sets `level` to 0 and clears `fifo_err`, and a push in the same cycle is neither stored nor counted as overrun. `flush` leaves `overrun` and the mode unchanged.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full leave `level` unchanged and advance the head. A pop on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1: queue of DEPTH entries; 0: single holding slot |
| flush | input | 1 | One-cycle strobe that empties the queue |
| push_valid | input | 1 | One-cycle strobe: a new character is offered |
| push_data | input | DATA_W | Character from the shift register |
| push_pe | input | 1 | Parity error of the offered character |
| push_fe | input | 1 | Framing error of the offered character |
| push_brk | input | 1 | Break condition of the offered character |
| pop | input | 1 | Host read of the head character |
| lsr_rd | input | 1 | Host read of line status; clears overrun |
| head_data | output | DATA_W | Oldest queued character |
| head_pe | output | 1 | Parity flag of the head character |
| head_fe | output | 1 | Framing flag of the head character |
| head_brk | output | 1 | Break flag of the head character |
| data_ready | output | 1 | At least one character is queued |
| overrun | output | 1 | A character was discarded since the last status read |
| fifo_err | output | 1 | Some queued character carries an error flag |
| level | output | $clog2(DEPTH+1) | Number of queued characters |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is an arriving character and a host read. The bench drives `push_valid` and `pop` together at three levels:
- On a partly filled queue, `level` must stay put while the head advances.
- On an empty queue, only the push takes effect.
- On a full queue, the pop is served, the push is discarded, and `overrun` rises.

The second pair is the overrun setting and the status read that clears it. The bench pushes into a full queue in the same cycle as `lsr_rd` and expects `overrun` to read 1 afterwards. It then issues `lsr_rd` alone and expects 0.

// File: rtl/rxh_pkg.sv
// Package: types shared by the receive holding buffer.
// Assumes: error flags are exactly parity, framing and break.
package rxh_pkg;
    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
    } rxh_err_t;

    localparam int ERR_W = 3;
endpackage

// File: rtl/rxh_store.sv
// Module: storage array, pointers and occupancy for the receive buffer.
// In queue mode the capacity is DEPTH; in single mode only slot zero is
// used and the capacity is one.
// Assumes: the mode changes only while empty; a push into a full buffer
// is refused even when a pop shares the cycle.
module rxh_store
    import rxh_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_en,
    input  logic                       flush,
    input  logic                       wr_req,
    input  logic [DATA_W-1:0]          wr_data,
    input  rxh_err_t                   wr_err,
    input  logic                       rd_req,
    output logic [DATA_W-1:0]          head_data,
    output rxh_err_t                   head_err,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       wr_ok,
    output logic                       rd_ok
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW  = $clog2(DEPTH + 1);
    localparam int EW  = DATA_W + ERR_W;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [LW-1:0] cap;
    logic          empty;

    // Capacity, status and the accept decisions for this cycle.
    always_comb begin
        cap   = fifo_en ? LW'(DEPTH) : LW'(1);
        empty = (level == '0);
        full  = (level == cap);
        wr_ok = wr_req && !full && !flush;
        rd_ok = rd_req && !empty && !flush;
    end

    // Single mode always addresses slot zero.
    always_comb begin
        wr_addr = fifo_en ? wr_ptr : '0;
        rd_addr = fifo_en ? rd_ptr : '0;
    end

    // Head entry is read straight from the array.
    always_comb begin
        {head_err, head_data} = mem[rd_addr];
    end

    // Write an accepted character and its flags into the array.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_addr] <= {wr_err, wr_data};
        end
    end

    // Pointer and occupancy update; flush returns everything to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_ok && fifo_en) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_ok && fifo_en) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/rxh_errcount.sv
// Module: counts queued entries that carry any error flag.
// Assumes: inc/dec only for pushes and pops that the store accepted.
module rxh_errcount #(
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic inc,
    input  logic dec,
    output logic any_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;

    // Track the number of damaged entries across pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // The summary flag is high while the count is non-zero.
    always_comb begin
        any_err = (cnt != '0);
    end
endmodule

// File: rtl/rxh_overrun.sv
// Module: sticky overrun flag.
// Assumes: set has priority over a clear in the same cycle.
module rxh_overrun (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag until a status read; a new loss wins over the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_hold_fifo.sv
// Module: receive holding buffer with per-character error flags and
// line-status summary bits.
// Assumes: inputs are synchronous to clk; fifo_en changes only while empty.
module rx_hold_fifo
    import rxh_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_en,
    input  logic                       flush,
    input  logic                       push_valid,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       push_pe,
    input  logic                       push_fe,
    input  logic                       push_brk,
    input  logic                       pop,
    input  logic                       lsr_rd,
    output logic [DATA_W-1:0]          head_data,
    output logic                       head_pe,
    output logic                       head_fe,
    output logic                       head_brk,
    output logic                       data_ready,
    output logic                       overrun,
    output logic                       fifo_err,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    rxh_err_t in_err, hd_err;
    logic     full, wr_ok, rd_ok;
    logic     lost;

    // Bundle the incoming flags.
    always_comb begin
        in_err = '{brk: push_brk, fe: push_fe, pe: push_pe};
    end

    rxh_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .flush     (flush),
        .wr_req    (push_valid),
        .wr_data   (push_data),
        .wr_err    (in_err),
        .rd_req    (pop),
        .head_data (head_data),
        .head_err  (hd_err),
        .level     (level),
        .full      (full),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok)
    );

    rxh_errcount #(.DEPTH(DEPTH)) u_errcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .inc     (wr_ok && (|in_err)),
        .dec     (rd_ok && (|hd_err)),
        .any_err (fifo_err)
    );

    // A character is lost when offered to a full buffer outside a flush.
    always_comb begin
        lost = push_valid && full && !flush;
    end

    rxh_overrun u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (lost),
        .clr   (lsr_rd),
        .flag  (overrun)
    );

    // Head flags and the data-ready status.
    always_comb begin
        head_pe    = hd_err.pe;
        head_fe    = hd_err.fe;
        head_brk   = hd_err.brk;
        data_ready = (level != '0);
    end
endmodule

// File: rtl/rxh_checker.sv
// Checker: temporal properties of the receive holding buffer, bound to the top.
module rxh_checker #(
    parameter int DEPTH = 64
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fifo_en,
    input logic                       flush,
    input logic                       push_valid,
    input logic                       pop,
    input logic                       lsr_rd,
    input logic                       data_ready,
    input logic                       overrun,
    input logic                       fifo_err,
    input logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0] cap;
    logic          at_cap;

    // Capacity as seen from the ports.
    always_comb begin
        cap    = fifo_en ? LW'(DEPTH) : LW'(1);
        at_cap = (level == cap);
    end

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= cap);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (at_cap && push_valid && !pop && !flush) |=> ($stable(level) && overrun));

    p_single_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (level <= LW'(1)));

    p_err_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_err |-> data_ready);

    p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !(push_valid && at_cap && !flush)) |=> !overrun);

    p_ready_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready == (level != '0));

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0 && !fifo_err));

    p_pushpop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && pop && !flush && level != '0 && !at_cap) |=> $stable(level));
endmodule

bind rx_hold_fifo rxh_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .flush      (flush),
    .push_valid (push_valid),
    .pop        (pop),
    .lsr_rd     (lsr_rd),
    .data_ready (data_ready),
    .overrun    (overrun),
    .fifo_err   (fifo_err),
    .level      (level)
);

// File: tb/tb_rx_hold_fifo.sv
`timescale 1ns/1ps
module tb_rx_hold_fifo;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic       flush = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       push_pe = 1'b0, push_fe = 1'b0, push_brk = 1'b0;
    logic       pop = 1'b0, lsr_rd = 1'b0;
    logic [7:0] head_data;
    logic       head_pe, head_fe, head_brk;
    logic       data_ready, overrun, fifo_err;
    logic [6:0] level;

    int checks = 0;
    int fails  = 0;

    // Reference model: entry = {brk, fe, pe, data}.
    int q[$];
    bit m_ovr = 0;

    always #2.5 clk = ~clk;

    rx_hold_fifo dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
        .push_valid(push_valid), .push_data(push_data), .push_pe(push_pe),
        .push_fe(push_fe), .push_brk(push_brk), .pop(pop), .lsr_rd(lsr_rd),
        .head_data(head_data), .head_pe(head_pe), .head_fe(head_fe),
        .head_brk(head_brk), .data_ready(data_ready), .overrun(overrun),
        .fifo_err(fifo_err), .level(level)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        bit any_e = 0;
        foreach (q[i]) if ((q[i] >> 8) != 0) any_e = 1;
        chk(tag, "level", int'(level), q.size());
        chk({tag, "/R8"}, "data_ready", int'(data_ready), int'(q.size() != 0));
        chk({tag, "/R6"}, "fifo_err", int'(fifo_err), int'(any_e));
        chk({tag, "/R7"}, "overrun", int'(overrun), int'(m_ovr));
        if (q.size() != 0) begin
            chk({tag, "/R5"}, "head", int'({head_brk, head_fe, head_pe, head_data}), q[0]);
        end
    endtask

    // One clock: drive at the falling edge, update the model, check after the edge.
    task automatic step(input bit ps, input int d, input int e, input bit pp,
                        input bit lr, input bit fl, input string tag);
        int  cap;
        bit  was_full;
        @(negedge clk);
        push_valid = ps; push_data = d[7:0];
        {push_brk, push_fe, push_pe} = e[2:0];
        pop = pp; lsr_rd = lr; flush = fl;
        @(posedge clk);
        cap = fifo_en ? DEPTH : 1;
        was_full = (q.size() == cap);
        if (fl) begin
            q.delete();
            if (lr) m_ovr = 0;
        end else begin
            if (ps && was_full) m_ovr = 1;
            else if (lr) m_ovr = 0;
            if (pp && q.size() != 0) void'(q.pop_front());
            if (ps && !was_full) q.push_back((e << 8) | (d & 255));
        end
        #1;
        push_valid = 0; pop = 0; lsr_rd = 0; flush = 0;
        compare(tag);
    endtask

    task automatic t_reset();
        compare("R1");
    endtask

    task automatic t_fifo_order();
        for (int i = 0; i < DEPTH; i++) step(1, i * 3 + 1, 0, 0, 0, 0, "R2");
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, 0, "R2");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH; i++) step(1, 200 - i, 0, 0, 0, 0, "R3");
        step(1, 8'hAA, 3, 0, 0, 0, "R3");
        step(1, 8'h55, 0, 1, 0, 0, "R3");
        for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 0, 1, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 0, "R3");
    endtask

    task automatic t_single();
        @(negedge clk); fifo_en = 0;
        step(1, 8'h11, 1, 0, 0, 0, "R4");
        step(1, 8'h22, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 1, 0, 0, "R4");
        step(1, 8'h33, 4, 0, 1, 0, "R4");
        step(0, 0, 0, 1, 0, 0, "R4");
        @(negedge clk); fifo_en = 1;
    endtask

    task automatic t_errors();
        step(1, 8'h01, 0, 0, 0, 0, "R5");
        step(1, 8'h02, 1, 0, 0, 0, "R5");
        step(1, 8'h03, 0, 0, 0, 0, "R6");
        step(1, 8'h04, 4, 0, 0, 0, "R6");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, "R6");
        step(1, 8'h05, 2, 0, 0, 0, "R5");
        step(0, 0, 0, 1, 0, 0, "R6");
    endtask

    task automatic t_ovr_clear();
        for (int i = 0; i < DEPTH; i++) step(1, i, 0, 0, 0, 0, "R7");
        step(1, 8'hEE, 0, 0, 1, 0, "R7");
        step(0, 0, 0, 0, 1, 0, "R7");
        step(0, 0, 0, 0, 0, 1, "R7");
    endtask

    task automatic t_flush();
        step(1, 8'h40, 7, 0, 0, 0, "R9");
        step(1, 8'h41, 2, 0, 0, 0, "R9");
        for (int i = 0; i < DEPTH; i++) step(1, i, 0, 0, 0, 0, "R9");
        step(1, 8'h42, 1, 0, 0, 1, "R9");
        step(1, 8'h43, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 1, 1, "R9");
    endtask

    task automatic t_pushpop();
        step(0, 0, 0, 1, 0, 0, "R10");
        step(1, 8'h60, 0, 1, 0, 0, "R10");
        step(1, 8'h61, 1, 0, 0, 0, "R10");
        step(1, 8'h62, 0, 1, 0, 0, "R10");
        step(1, 8'h63, 2, 1, 0, 0, "R10");
        for (int i = 0; i < DEPTH - 2; i++) step(1, i, 0, 0, 0, 0, "R10");
        step(1, 8'h77, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 1, 1, "R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_fifo_order();
        t_overflow();
        t_single();
        t_errors();
        t_ovr_clear();
        t_flush();
        t_pushpop();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule